// File: doc/BRIEF.md
# Energy Pulse Output Shaper

The shaper turns single-cycle pulse requests from an energy accumulator into pulses on one output pin. Requests can arrive at any rate. Normally each request produces an active phase whose length is the programmed width in clock cycles. When requests arrive too fast for that width to fit, the active phase shrinks to half of the last measured request interval, so the output becomes a square wave with 50% duty cycle that follows the request rate.

The block measures the number of cycles between the two most recent requests and chooses the active length when each request arrives. A polarity control acts only at the output stage. It selects whether the active phase is driven low or high, and it never changes when a pulse starts or ends. A width of zero silences the pin.

Top module: `eps_pulse_shaper`

## Requirements
- R1: When there is no valid interval measurement, or half the measured interval is not below the programmed width, a request starts an active phase that lasts exactly `width` cycles. The pin is active in the `width` cycles that follow the clock edge at which `req` is sampled high.
- R2: The interval is the number of clock edges from one sampled request to the next. It saturates at 2^(WIDTH_W+1)-1 and does not wrap, so a very long gap behaves like no measurement.
- R3: When a measurement exists and floor(interval/2) is below `width`, the active phase lasts floor(interval/2) cycles, with a minimum of 1 cycle.
- R4: With `invert` at 0, the pin idles at 1 and the active phase drives 0.
- R5: With `invert` at 1, the pin idles at 0 and the active phase drives 1.
- R6: A request that arrives during an active phase ends that phase and starts a new one, with its length chosen by R1 or R3. No request is lost.
- R7: A request sampled while `width` is 0 produces no active phase, and any running phase ends, so the pin returns to idle.
- R8: Changing `invert` in the middle of a pulse changes the pin level at once, but the cycle in which the pulse ends does not move.
- R9: While `rst_n` is low at a clock edge, the pulse ends and the interval measurement is cleared. The first request after reset therefore uses the full width of R1.
- R10: The length is fixed when the request is sampled. Changing `width` during a pulse does not change that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Single-cycle pulse request strobe |
| width | input | WIDTH_W | Programmed active length in clock cycles |
| invert | input | 1 | 0: active-low pulses, 1: active-high pulses |
| pulse_out | output | 1 | Shaped pulse pin |

## Verification
Ending the current pulse and starting the next one can fall in the same cycle. This happens whenever the request period is no longer than the programmed width. The bench provokes it by sweeping every width against request periods both shorter and longer than that width. In each period it compares every cycle's pin level with the length computed arithmetically from R1 and R3. A reload that was dropped or came late would show up as a wrong level right at the period boundary. A second overlap, a polarity change in the middle of a pulse, is judged by checking that the pulse still ends in the cycle the width predicts.

// File: rtl/eps_pkg.sv
// Package: shared types for the energy pulse shaper.
// Assumes nothing beyond standard SystemVerilog.
package eps_pkg;
    // Tells whether the interval meter holds a real measurement.
    typedef enum logic {
        MEAS_NONE  = 1'b0,
        MEAS_VALID = 1'b1
    } meas_state_t;
endpackage

// File: rtl/eps_interval_meter.sv
// Interval meter: counts the clock edges since the last sampled request.
// At the edge of a new request, meas_o holds the interval to the previous one.
// Assumes req_i is synchronous to clk. The count saturates at all ones.
module eps_interval_meter
    import eps_pkg::*;
#(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    output logic [CW-1:0] meas_o,
    output logic          meas_valid_o
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [CW-1:0] cnt_q;
    meas_state_t   state_q;

    // Restart the count on each request and saturate it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (req_i) begin
            cnt_q <= {{(CW-1){1'b0}}, 1'b1};
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Mark the measurement valid once a first request has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MEAS_NONE;
        end else if (req_i) begin
            state_q <= MEAS_VALID;
        end
    end

    assign meas_o       = cnt_q;
    assign meas_valid_o = (state_q == MEAS_VALID);

    assert_meas_saturates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_i && meas_o == CNT_MAX) |=> (meas_o == CNT_MAX));
    assert_meas_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> (meas_o == {{(CW-1){1'b0}}, 1'b1} && meas_valid_o));
    assert_meas_cleared_R9: assert property (@(posedge clk)
        !rst_n |=> !meas_valid_o);
endmodule

// File: rtl/eps_length_select.sv
// Length selector: picks the active length for a new request.
// It uses the full width unless half the measured interval is shorter.
// If it uses half the interval, the result is at least 1. A zero width gives 0.
// Assumes CW = W + 1, so half of the interval fits in W bits.
module eps_length_select #(
    parameter int W  = 8,
    parameter int CW = W + 1
) (
    input  logic [W-1:0]  width_i,
    input  logic [CW-1:0] meas_i,
    input  logic          meas_valid_i,
    output logic [W-1:0]  length_o
);
    logic [CW-2:0] half;

    // Choose between the programmed width and half of the last interval.
    always_comb begin
        half = meas_i[CW-1:1];
        if (width_i == '0) begin
            length_o = '0;
        end else if (meas_valid_i && (half < width_i)) begin
            length_o = (half == '0) ? {{(W-1){1'b0}}, 1'b1} : half[W-1:0];
        end else begin
            length_o = width_i;
        end
    end

    // R1, R3: the chosen length never exceeds the programmed width.
    always_comb begin
        assert_len_within_width_R1: assert (length_o <= width_i);
    end
endmodule

// File: rtl/eps_pulse_timer.sv
// Pulse timer: loads the chosen length on each request and counts down.
// active_o is high while the count is non-zero. A request always reloads.
// Assumes req_i is a single-cycle strobe.
module eps_pulse_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_i,
    input  logic [W-1:0] length_i,
    output logic         active_o
);
    logic [W-1:0] rem_q;

    // Reload on a request and count down toward idle otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (req_i) begin
            rem_q <= length_i;
        end else if (rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    assign active_o = (rem_q != '0);

    assert_reset_idle_R9: assert property (@(posedge clk)
        !rst_n |=> !active_o);
    assert_countdown_monotonic_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_i && !active_o) |=> !active_o);
endmodule

// File: rtl/eps_polarity_stage.sv
// Polarity stage: maps the internal active flag onto the pin level.
// It is purely combinational, so polarity never affects timing.
module eps_polarity_stage (
    input  logic active_i,
    input  logic invert_i,
    output logic pin_o
);
    // Active drives the invert level. Idle drives its complement.
    always_comb begin
        pin_o = active_i ? invert_i : ~invert_i;
    end
endmodule

// File: rtl/eps_pulse_shaper.sv
// Top: energy pulse output shaper.
// It measures the request interval, selects the pulse length, times the
// pulse and applies the polarity. Assumes synchronous inputs and a width
// that is at least 0. width is sampled only on a request.
module eps_pulse_shaper #(
    parameter int WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [WIDTH_W-1:0] width,
    input  logic               invert,
    output logic               pulse_out
);
    localparam int CW = WIDTH_W + 1;

    logic [CW-1:0]      meas;
    logic               meas_valid;
    logic [WIDTH_W-1:0] length;
    logic               active;

    eps_interval_meter #(.CW(CW)) u_meter (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req),
        .meas_o       (meas),
        .meas_valid_o (meas_valid)
    );

    eps_length_select #(.W(WIDTH_W), .CW(CW)) u_select (
        .width_i      (width),
        .meas_i       (meas),
        .meas_valid_i (meas_valid),
        .length_o     (length)
    );

    eps_pulse_timer #(.W(WIDTH_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req),
        .length_i (length),
        .active_o (active)
    );

    eps_polarity_stage u_pol (
        .active_i (active),
        .invert_i (invert),
        .pin_o    (pulse_out)
    );

    assert_zero_width_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && width == '0) |=> !active);
    assert_restart_on_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && width != '0) |=> active);
    assert_first_full_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !meas_valid) |=> (length == width || $past(length) == $past(width)));
endmodule

// File: tb/eps_pulse_shaper_tb.sv
module eps_pulse_shaper_tb;
    localparam int W = 4;
    localparam int MAXW = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req = 1'b0;
    logic [W-1:0] width = '0;
    logic         invert = 1'b0;
    logic         pulse_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    eps_pulse_shaper #(.WIDTH_W(W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .width     (width),
        .invert    (invert),
        .pulse_out (pulse_out)
    );

    always #10 clk = ~clk;

    // Advance one clock edge with the given request value. Afterwards the
    // bench is at the next falling edge, away from the active edge.
    task automatic tick(input logic r);
        req = r;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic check_level(input bit exp_active, input string tag);
        logic exp;
        exp = exp_active ? invert : ~invert;
        checks++;
        if (pulse_out !== exp) begin
            failures++;
            $display("FAIL %s: pulse_out=%b expected=%b (inv=%b w=%0d)",
                     tag, pulse_out, exp, invert, width);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_level(1'b0, "R9 reset idle");
        rst_n = 1'b1;
    endtask

    // Expected active length for a request that follows an interval p.
    function automatic int exp_len(input int w, input int p, input bit has_meas);
        int half;
        int pe;
        if (w == 0) return 0;
        if (!has_meas) return w;
        pe = (p > 2 * MAXW + 1) ? 2 * MAXW + 1 : p;
        half = pe / 2;
        if (half < w) return (half == 0) ? 1 : half;
        return w;
    endfunction

    // Send n requests spaced p edges apart and check every cycle.
    task automatic run_train(input int w, input int p, input int n);
        int len;
        string tag;
        width = w[W-1:0];
        do_reset();
        for (int k = 0; k < n; k++) begin
            len = exp_len(w, p, k != 0);
            if (w == 0) tag = "R7 zero width";
            else if (k == 0) tag = "R1 first full width";
            else if (len < w) tag = "R3 halved interval";
            else tag = (p > 2 * MAXW) ? "R2 saturated interval" : "R1 full width";
            tick(1'b1);
            check_level(1 <= len, tag);
            for (int j = 2; j <= p; j++) begin
                tick(1'b0);
                check_level(j <= len, (j == p && p <= w) ? "R6 restart boundary" : tag);
            end
        end
        for (int j = 0; j < 3; j++) begin
            tick(1'b0);
            if (p >= exp_len(w, p, n > 1)) check_level(1'b0, "R1 tail idle");
        end
    endtask

    initial begin
        // Sweep over widths, request periods and both polarities (R4, R5).
        for (int pol = 0; pol < 2; pol++) begin
            invert = pol[0];
            for (int w = 0; w <= 8; w++) begin
                for (int p = 1; p <= 19; p++) begin
                    run_train(w, p, 4);
                end
            end
        end

        // R2: a gap beyond the counter range must not wrap.
        invert = 1'b0;
        run_train(MAXW, 40, 3);
        run_train(MAXW, 31, 3);

        // R4 and R5: explicit idle levels.
        invert = 1'b0;
        do_reset();
        tick(1'b0);
        checks++;
        if (pulse_out !== 1'b1) begin
            failures++;
            $display("FAIL R4 idle: pulse_out=%b expected=1", pulse_out);
        end
        invert = 1'b1;
        #1;
        checks++;
        if (pulse_out !== 1'b0) begin
            failures++;
            $display("FAIL R5 idle: pulse_out=%b expected=0", pulse_out);
        end

        // R8: flip the polarity in the middle of a pulse; the end cycle must not move.
        invert = 1'b0;
        width = 4'd6;
        do_reset();
        tick(1'b1);
        check_level(1'b1, "R8 pulse start");
        tick(1'b0);
        invert = 1'b1;
        #1;
        check_level(1'b1, "R8 after flip");
        for (int j = 3; j <= 8; j++) begin
            tick(1'b0);
            check_level(j <= 6, "R8 end unchanged");
        end

        // R10: changing the width during a pulse does not alter it.
        invert = 1'b0;
        width = 4'd5;
        do_reset();
        tick(1'b1);
        width = 4'd12;
        for (int j = 2; j <= 8; j++) begin
            tick(1'b0);
            check_level(j <= 5, "R10 width latched");
        end

        // R9: a reset clears the measurement, so a fast request gets the full width.
        width = 4'd8;
        do_reset();
        tick(1'b1);
        tick(1'b0);
        tick(1'b1);
        do_reset();
        tick(1'b1);
        for (int j = 2; j <= 10; j++) begin
            tick(1'b0);
            check_level(j <= 8, "R9 measurement cleared");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule